// File: doc/BRIEF.md
# Program Counter and Page Register Unit

This unit owns the sequencer's program counter and a separate page register. Each clock the sequencer presents a 4-bit control code, a resolved target word and three zero indications (Accumulator, X, Y). The unit then advances the program counter by one or two words, loads it with the target, moves it to the start of the current page, or resolves a zero-test branch. Memory access and instruction decode are handled elsewhere.

The page register holds a page number, not an address. A page jump converts it to an address by multiplying it by 0xFF, so page 1 starts at 0x00FF. The page register can be incremented or decremented. Those two operations, and only those, update a private set of five status flags: carry, zero, overflow, parity and negative. Every update becomes visible on the outputs right after the clock edge that samples the control code.

Top module: `pc_page_unit`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, `pc`, `page` and all five flags read zero.
- R2: Code 0 (hold) and every code from 10 to 15 leave `pc`, `page` and the flags unchanged.
- R3: Code 1 (step) sets `pc` to `pc`+1 modulo 2^16, so 0xFFFF wraps to 0x0000.
- R4: Code 2 (skip operand) sets `pc` to `pc`+2 modulo 2^16.
- R5: Code 3 (jump) loads `pc` with `target`.
- R6: Code 4 (page jump) loads `pc` with (`page` * 0xFF) modulo 2^16; page 1 gives 0x00FF.
- R7: Codes 5, 6 and 7 test `acc_zero`, `x_zero` and `y_zero` respectively. When the tested input is 1, `pc` loads `target`; otherwise `pc` becomes `pc`+2.
- R8: Code 8 (page increment) sets `page` to `page`+1 modulo 2^16 and `pc` to `pc`+1. `flag_carry` is set when the old page was 0xFFFF. `flag_ovf` is set when the old page was 0x7FFF.
- R9: Code 9 (page decrement) sets `page` to `page`-1 modulo 2^16 and `pc` to `pc`+1. `flag_carry` is set (as a borrow) when the old page was 0x0000. `flag_ovf` is set when the old page was 0x8000.
- R10: After codes 8 or 9, `flag_zero` equals (new page == 0), `flag_parity` equals bit 0 of the new page and `flag_neg` equals bit 15 of the new page.
- R11: Codes other than 8 and 9, branches included, leave `page` and all five flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_op | input | 4 | Control code for this cycle |
| target | input | 16 | Resolved jump or branch target word |
| acc_zero | input | 1 | Accumulator equals zero |
| x_zero | input | 1 | X register equals zero |
| y_zero | input | 1 | Y register equals zero |
| pc | output | 16 | Program counter |
| page | output | 16 | Page register (page number) |
| flag_carry | output | 1 | Carry or borrow of the last page update |
| flag_zero | output | 1 | Last page update gave zero |
| flag_ovf | output | 1 | Signed overflow of the last page update |
| flag_parity | output | 1 | Bit 0 of the last page result |
| flag_neg | output | 1 | Bit 15 of the last page result |

## Verification
All state in this unit is architectural and appears directly on the outputs, so a wrong program counter, page value or flag is visible one cycle after the faulty update. The later effects are harder to spot. A wrong page value can stay hidden until a page jump multiplies it into `pc`. A flag that changes when it should not only shows if the next cycles do not overwrite it. For these reasons, every output is compared against a model on every cycle. The stimulus walks the page register through both wrap points and both signed boundaries, and it mixes in random codes so that stale or disturbed flags show up.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [3:0] {
    OP_HOLD   = 4'd0,
    OP_STEP   = 4'd1,
    OP_SKIP   = 4'd2,
    OP_JUMP   = 4'd3,
    OP_PGJMP  = 4'd4,
    OP_BR_A   = 4'd5,
    OP_BR_X   = 4'd6,
    OP_BR_Y   = 4'd7,
    OP_PG_INC = 4'd8,
    OP_PG_DEC = 4'd9
  } pc_op_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic ovf;
    logic parity;
    logic neg;
  } pg_flags_t;

endpackage

// File: rtl/pcu_branch_cond.sv
module pcu_branch_cond
  import pcu_pkg::*;
(
  input  logic [3:0] op,
  input  logic       acc_zero,
  input  logic       x_zero,
  input  logic       y_zero,
  output logic       is_branch,
  output logic       take
);
  always_comb begin
    is_branch = 1'b0;
    take      = 1'b0;
    unique case (op)
      OP_BR_A: begin is_branch = 1'b1; take = acc_zero; end
      OP_BR_X: begin is_branch = 1'b1; take = x_zero;   end
      OP_BR_Y: begin is_branch = 1'b1; take = y_zero;   end
      default: ;
    endcase
  end
endmodule

// File: rtl/pcu_page_alu.sv
module pcu_page_alu
  import pcu_pkg::*;
#(
  parameter int W = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op,
  output logic [W-1:0] page_q,
  output pg_flags_t    flags_q,
  output logic         page_upd
);
  localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

  // Returns {carry_or_borrow, overflow, result}.
  function automatic logic [W+1:0] page_step(input logic [W-1:0] p, input logic dec);
    logic [W:0] ext;
    logic       ov;
    ext = dec ? ({1'b0, p} - ONE_X) : ({1'b0, p} + ONE_X);
    ov  = dec ? (p[W-1] & ~ext[W-1]) : (~p[W-1] & ext[W-1]);
    return {ext[W], ov, ext[W-1:0]};
  endfunction

  logic [W+1:0] step_res;
  logic [W-1:0] new_page;
  pg_flags_t    new_flags;

  assign page_upd = (op == OP_PG_INC) || (op == OP_PG_DEC);
  assign step_res = page_step(page_q, op == OP_PG_DEC);
  assign new_page = step_res[W-1:0];

  always_comb begin
    new_flags.carry  = step_res[W+1];
    new_flags.ovf    = step_res[W];
    new_flags.zero   = (new_page == '0);
    new_flags.parity = new_page[0];
    new_flags.neg    = new_page[W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      flags_q <= '0;
    end else if (page_upd) begin
      page_q  <= new_page;
      flags_q <= new_flags;
    end
  end
endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
  import pcu_pkg::*;
#(
  parameter int W    = 16,
  parameter int SPAN = 255
)(
  input  logic [3:0]   op,
  input  logic [W-1:0] pc_q,
  input  logic [W-1:0] page_q,
  input  logic [W-1:0] target,
  input  logic         is_branch,
  input  logic         take,
  output logic [W-1:0] pc_nxt
);
  localparam logic [W-1:0] SPAN_W = SPAN[W-1:0];
  localparam logic [W-1:0] ONE_W  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] TWO_W  = ONE_W << 1;

  function automatic logic [W-1:0] page_base(input logic [W-1:0] p);
    logic [2*W-1:0] prod;
    prod = {{W{1'b0}}, p} * {{W{1'b0}}, SPAN_W};
    return prod[W-1:0];
  endfunction

  always_comb begin
    pc_nxt = pc_q;
    if (is_branch) begin
      pc_nxt = take ? target : (pc_q + TWO_W);
    end else begin
      case (op)
        OP_STEP, OP_PG_INC, OP_PG_DEC: pc_nxt = pc_q + ONE_W;
        OP_SKIP:                       pc_nxt = pc_q + TWO_W;
        OP_JUMP:                       pc_nxt = target;
        OP_PGJMP:                      pc_nxt = page_base(page_q);
        default:                       pc_nxt = pc_q;
      endcase
    end
  end
endmodule

// File: rtl/pc_page_unit.sv
module pc_page_unit
  import pcu_pkg::*;
#(
  parameter int W    = 16,
  parameter int SPAN = 255
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   ctl_op,
  input  logic [W-1:0] target,
  input  logic         acc_zero,
  input  logic         x_zero,
  input  logic         y_zero,
  output logic [W-1:0] pc,
  output logic [W-1:0] page,
  output logic         flag_carry,
  output logic         flag_zero,
  output logic         flag_ovf,
  output logic         flag_parity,
  output logic         flag_neg
);
  logic [W-1:0] pc_q;
  logic [W-1:0] pc_nxt;
  logic [W-1:0] page_q;
  pg_flags_t    flags_q;
  logic         is_branch;
  logic         take_branch;
  logic         page_upd;

  pcu_branch_cond u_cond (
    .op        (ctl_op),
    .acc_zero  (acc_zero),
    .x_zero    (x_zero),
    .y_zero    (y_zero),
    .is_branch (is_branch),
    .take      (take_branch)
  );

  pcu_page_alu #(.W(W)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (ctl_op),
    .page_q   (page_q),
    .flags_q  (flags_q),
    .page_upd (page_upd)
  );

  pcu_next_pc #(.W(W), .SPAN(SPAN)) u_npc (
    .op        (ctl_op),
    .pc_q      (pc_q),
    .page_q    (page_q),
    .target    (target),
    .is_branch (is_branch),
    .take      (take_branch),
    .pc_nxt    (pc_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  assign pc          = pc_q;
  assign page        = page_q;
  assign flag_carry  = flags_q.carry;
  assign flag_zero   = flags_q.zero;
  assign flag_ovf    = flags_q.ovf;
  assign flag_parity = flags_q.parity;
  assign flag_neg    = flags_q.neg;
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int W = 16
)(
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   ctl_op,
  input logic [W-1:0] target,
  input logic         acc_zero,
  input logic [W-1:0] pc,
  input logic [W-1:0] page,
  input logic         flag_zero,
  input logic         flag_parity,
  input logic         flag_neg,
  input logic [4:0]   flags_all,
  input logic         take_branch,
  input logic         page_upd
);
  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  a_r1_reset_pc: assert property (@(posedge clk) !rst_n |=> (pc == '0 && page == '0 && flags_all == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ctl_op == 4'd1) |=> pc == $past(pc) + 1'b1);

  a_r4_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ctl_op == 4'd2) |=> pc == $past(pc) + 2'd2);

  a_r5_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ctl_op == 4'd3) |=> pc == $past(target));

  a_r7_branch_a: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ctl_op == 4'd5 && acc_zero) |=> pc == $past(target));

  a_r7_untaken: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ctl_op >= 4'd5 && ctl_op <= 4'd7 && !take_branch) |=> pc == $past(pc) + 2'd2);

  a_r10_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (live && page_upd) |=> (flag_zero == (page == '0) && flag_parity == page[0] && flag_neg == page[W-1]));

  a_r11_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !page_upd) |=> ($stable(page) && $stable(flags_all)));
endmodule

bind pc_page_unit pcu_checker #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_op      (ctl_op),
  .target      (target),
  .acc_zero    (acc_zero),
  .pc          (pc),
  .page        (page),
  .flag_zero   (flag_zero),
  .flag_parity (flag_parity),
  .flag_neg    (flag_neg),
  .flags_all   ({flag_carry, flag_zero, flag_ovf, flag_parity, flag_neg}),
  .take_branch (take_branch),
  .page_upd    (page_upd)
);

// File: tb/pc_page_unit_test.sv
module pc_page_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ctl_op = 4'd0;
  logic [15:0] target = 16'd0;
  logic        acc_zero = 1'b0, x_zero = 1'b0, y_zero = 1'b0;
  logic [15:0] pc, page;
  logic        flag_carry, flag_zero, flag_ovf, flag_parity, flag_neg;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int m_pc = 0, m_pg = 0;
  bit mc = 0, mz = 0, mo = 0, mp = 0, mn = 0;

  always #4 clk = ~clk;   // 125 MHz

  pc_page_unit uut (
    .clk(clk), .rst_n(rst_n), .ctl_op(ctl_op), .target(target),
    .acc_zero(acc_zero), .x_zero(x_zero), .y_zero(y_zero),
    .pc(pc), .page(page), .flag_carry(flag_carry), .flag_zero(flag_zero),
    .flag_ovf(flag_ovf), .flag_parity(flag_parity), .flag_neg(flag_neg)
  );

  function automatic string tag_of(int op);
    case (op)
      0: return "R2,R11";
      1: return "R3,R11";
      2: return "R4,R11";
      3: return "R5,R11";
      4: return "R6,R11";
      5, 6, 7: return "R7,R11";
      8: return "R8,R10";
      9: return "R9,R10";
      default: return "R2,R11";
    endcase
  endfunction

  task automatic compare(string tag);
    logic [36:0] act, exp;
    act = {pc, page, flag_carry, flag_zero, flag_ovf, flag_parity, flag_neg};
    exp = {m_pc[15:0], m_pg[15:0], mc, mz, mo, mp, mn};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pc/page/cZvPn actual=%h/%h/%b expected=%h/%h/%b", tag,
               act[36:21], act[20:5], act[4:0], exp[36:21], exp[20:5], exp[4:0]);
    end
  endtask

  task automatic model(int op, int tgt, bit az, bit xz, bit yz);
    int old;
    case (op)
      1: m_pc = (m_pc + 1) % 65536;
      2: m_pc = (m_pc + 2) % 65536;
      3: m_pc = tgt;
      4: m_pc = (m_pg * 255) % 65536;
      5: m_pc = az ? tgt : (m_pc + 2) % 65536;
      6: m_pc = xz ? tgt : (m_pc + 2) % 65536;
      7: m_pc = yz ? tgt : (m_pc + 2) % 65536;
      8, 9: begin
        old = m_pg;
        if (op == 8) begin
          m_pg = (old + 1) % 65536;
          mc = (old == 65535);
          mo = (old == 32767);
        end else begin
          m_pg = (old + 65535) % 65536;
          mc = (old == 0);
          mo = (old == 32768);
        end
        mz = (m_pg == 0);
        mp = m_pg[0];
        mn = (m_pg >= 32768);
        m_pc = (m_pc + 1) % 65536;
      end
      default: ;
    endcase
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic apply(int op, int tgt, bit az, bit xz, bit yz);
    ctl_op = op[3:0]; target = tgt[15:0];
    acc_zero = az; x_zero = xz; y_zero = yz;
    @(posedge clk);
    model(op, tgt, az, xz, yz);
    @(negedge clk);
    compare(tag_of(op));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");                          // R1 during reset
    ctl_op = 4'd1;                          // must be ignored in reset
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    ctl_op = 4'd0;

    apply(0, 0, 0, 0, 0);                   // R2 hold
    apply(1, 0, 0, 0, 0);                   // R3
    apply(2, 0, 0, 0, 0);                   // R4
    apply(3, 16'hFFFF, 0, 0, 0);            // R5
    apply(1, 0, 0, 0, 0);                   // R3 wrap to 0
    apply(2, 16'h1234, 0, 0, 0);            // R4
    apply(8, 0, 0, 0, 0);                   // R8 page 0 -> 1
    apply(4, 0, 0, 0, 0);                   // R6 page 1 -> 0x00FF
    apply(12, 16'hAAAA, 1, 1, 1);           // R2 undefined code
    apply(15, 16'h5555, 1, 1, 1);           // R2
    apply(5, 16'h4000, 1, 0, 0);            // R7 taken A
    apply(5, 16'h0100, 0, 1, 1);            // R7 untaken A
    apply(6, 16'h2222, 0, 1, 0);            // R7 taken X
    apply(6, 16'h3333, 1, 0, 1);            // R7 untaken X
    apply(7, 16'h7777, 0, 0, 1);            // R7 taken Y
    apply(7, 16'h8888, 1, 1, 0);            // R7 untaken Y
    apply(9, 0, 0, 0, 0);                   // R9 page 1 -> 0, zero flag
    apply(9, 0, 0, 0, 0);                   // R9 borrow 0 -> FFFF, neg
    apply(4, 0, 0, 0, 0);                   // R6 0xFFFF*0xFF mod 2^16
    apply(8, 0, 0, 0, 0);                   // R8 carry FFFF -> 0
    apply(9, 0, 0, 0, 0);                   // back to FFFF
    while (m_pg != 32768) apply(9, 0, 0, 0, 0);
    apply(9, 0, 0, 0, 0);                   // R9 overflow 8000 -> 7FFF
    apply(4, 0, 0, 0, 0);                   // R6 large page
    apply(8, 0, 0, 0, 0);                   // R8 overflow 7FFF -> 8000
    apply(3, 16'h0001, 0, 0, 0);            // R11 flags held across jump

    for (int i = 0; i < 400; i++) begin
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)),
            1'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule